// File: doc/BRIEF.md
# Synthesizer Serial Programming Register

This block is the three-wire load port that holds the control words of a frequency synthesizer. A host drives a serial data line, a serial clock and a load-enable line. Each word is 21 bits long, sent most significant bit first and sampled on the rising edge of the serial clock. When load-enable rises, the two bits shifted in last choose where the other 19 bits go: the reference divider latch, the feedback divider latch, or the function latch. A fourth code also writes the function latch and issues a counter-reset strobe.

All three serial inputs are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and the serial clock is oversampled. Words that would program a divider out of range are refused: the latch keeps its old contents and a sticky error flag is set. After an initialization word, the first accepted feedback divider load fires the reset strobe one more time. Later feedback loads do not fire it.

Top module: `synth_serial_port`

## Requirements
- R1: After reset, every latched field, the reset strobe and the error flag are zero.
- R2: The shift register keeps the last 21 bits sampled on serial clock rising edges. The first bit of a word ends up in word bit 20. Bits sent before those 21 bits have no effect.
- R3: Selection uses word bits [1:0]. Bit 1 is the next-to-last bit sent and bit 0 is the last bit sent. Code 2'b00 loads the reference latch: the divide ratio from word bits [15:2] and the lock precision bit from word bit 20.
- R4: Code 2'b10 loads the feedback latch: the GO bit from word bit 20, the B count from word bits [19:7] and the A count from word bits [6:2].
- R5: Code 2'b01 loads the 18-bit function field from word bits [19:2] and does not pulse the reset strobe.
- R6: Code 2'b11 loads the function field in the same way and pulses the reset strobe.
- R7: After a code 2'b11 word, the first accepted code 2'b10 word pulses the reset strobe again. Further code 2'b10 words do not pulse it until another code 2'b11 word arrives.
- R8: Each reset strobe is high for exactly one system clock cycle.
- R9: A reference word with a divide ratio below 3 sets the error flag and leaves the reference latch unchanged.
- R10: A feedback word with B below 3, or with B below A, sets the error flag, leaves the feedback latch unchanged, and does not use up a pending reset from R7.
- R11: The error flag stays set until reset.
- R12: No output changes unless load-enable rises. Serial clocking while load-enable is low leaves every output as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load-enable, asynchronous |
| ref_ratio | output | 14 | Reference divide ratio |
| ref_prec | output | 1 | Lock-detect precision bit |
| fb_go | output | 1 | GO bit of the feedback word |
| fb_b | output | 13 | Feedback B count |
| fb_a | output | 5 | Feedback A count |
| func_bits | output | 18 | Function latch contents |
| cnt_rst | output | 1 | One-cycle counter-reset strobe |
| cfg_err | output | 1 | Sticky illegal-word flag |

## Verification
Two functions can fall in the same load: writing the feedback latch and firing the pending one-shot reset. When they coincide, the latch update and the strobe must appear in the same cycle. The bench provokes this with an initialization word followed by a feedback word. It also places a refused feedback word between the two and expects no strobe on the refused word and one strobe on the next legal feedback word. Strobe cycles are counted per load, and every load is judged against a bench model of the latches, the pending flag and the error flag.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam int WORD_W = 21;
  localparam int CODE_W = 2;
  localparam int PAY_W  = WORD_W - CODE_W;
  localparam int RAT_W  = 14;
  localparam int BCNT_W = 13;
  localparam int ACNT_W = 5;
  localparam int FN_W   = 18;
  localparam int MIN_DIV = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_REF  = 2'b00,
    CODE_FUNC = 2'b01,
    CODE_FB   = 2'b10,
    CODE_INIT = 2'b11
  } code_t;

  function automatic logic ratio_legal(input logic [RAT_W-1:0] r);
    return r >= RAT_W'(MIN_DIV);
  endfunction

  function automatic logic fb_legal(input logic [BCNT_W-1:0] b, input logic [ACNT_W-1:0] a);
    return (b >= BCNT_W'(MIN_DIV)) && (b >= BCNT_W'(a));
  endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= '0;
    else        last <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/sp_shift.sv
module sp_shift #(
  parameter int WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], din};
  end
endmodule

// File: rtl/sp_load_ctrl.sv
module sp_load_ctrl
  import synth_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              le_rise,
  input  logic [WORD_W-1:0] word,
  output code_t             code,
  output logic              bad_word,
  output logic [RAT_W-1:0]  ref_ratio,
  output logic              ref_prec,
  output logic              fb_go,
  output logic [BCNT_W-1:0] fb_b,
  output logic [ACNT_W-1:0] fb_a,
  output logic [FN_W-1:0]   func_bits,
  output logic              cnt_rst,
  output logic              cfg_err,
  output logic              rst_armed
);
  logic [PAY_W-1:0]  pay;
  logic [RAT_W-1:0]  w_ratio;
  logic [BCNT_W-1:0] w_b;
  logic [ACNT_W-1:0] w_a;
  logic              w_top;

  assign code    = code_t'(word[CODE_W-1:0]);
  assign pay     = word[WORD_W-1:CODE_W];
  assign w_top   = pay[PAY_W-1];
  assign w_ratio = pay[RAT_W-1:0];
  assign w_b     = pay[ACNT_W+BCNT_W-1:ACNT_W];
  assign w_a     = pay[ACNT_W-1:0];

  always_comb begin
    unique case (code)
      CODE_REF: bad_word = !ratio_legal(w_ratio);
      CODE_FB:  bad_word = !fb_legal(w_b, w_a);
      default:  bad_word = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_ratio <= '0;
      ref_prec  <= 1'b0;
      fb_go     <= 1'b0;
      fb_b      <= '0;
      fb_a      <= '0;
      func_bits <= '0;
      cnt_rst   <= 1'b0;
      cfg_err   <= 1'b0;
      rst_armed <= 1'b0;
    end else begin
      cnt_rst <= 1'b0;
      if (le_rise) begin
        if (bad_word) cfg_err <= 1'b1;
        unique case (code)
          CODE_REF: if (!bad_word) begin
            ref_ratio <= w_ratio;
            ref_prec  <= w_top;
          end
          CODE_FB: if (!bad_word) begin
            fb_go <= w_top;
            fb_b  <= w_b;
            fb_a  <= w_a;
            if (rst_armed) begin
              cnt_rst   <= 1'b1;
              rst_armed <= 1'b0;
            end
          end
          CODE_FUNC: func_bits <= pay[FN_W-1:0];
          CODE_INIT: begin
            func_bits <= pay[FN_W-1:0];
            cnt_rst   <= 1'b1;
            rst_armed <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_serial_port.sv
module synth_serial_port
  import synth_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic [RAT_W-1:0]  ref_ratio,
  output logic              ref_prec,
  output logic              fb_go,
  output logic [BCNT_W-1:0] fb_b,
  output logic [ACNT_W-1:0] fb_a,
  output logic [FN_W-1:0]   func_bits,
  output logic              cnt_rst,
  output logic              cfg_err
);
  logic [2:0]        s_level;
  logic [2:0]        s_rise;
  logic              sck_rise;
  logic              le_rise;
  logic              dat_s;
  logic [WORD_W-1:0] shift_word;
  code_t             word_code;
  logic              bad_word;
  logic              rst_armed;

  sp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({ser_le, ser_dat, ser_clk}),
    .level(s_level), .rise(s_rise)
  );

  assign sck_rise = s_rise[0];
  assign dat_s    = s_level[1];
  assign le_rise  = s_rise[2];

  sp_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(sck_rise), .din(dat_s), .word(shift_word)
  );

  sp_load_ctrl u_load (
    .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .word(shift_word),
    .code(word_code), .bad_word(bad_word),
    .ref_ratio(ref_ratio), .ref_prec(ref_prec),
    .fb_go(fb_go), .fb_b(fb_b), .fb_a(fb_a),
    .func_bits(func_bits), .cnt_rst(cnt_rst), .cfg_err(cfg_err),
    .rst_armed(rst_armed)
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker
  import synth_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              le_rise,
  input code_t             word_code,
  input logic              bad_word,
  input logic              rst_armed,
  input logic [RAT_W-1:0]  ref_ratio,
  input logic [BCNT_W-1:0] fb_b,
  input logic [ACNT_W-1:0] fb_a,
  input logic [FN_W-1:0]   func_bits,
  input logic              cnt_rst,
  input logic              cfg_err
);
  a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> !cnt_rst);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r12_quiet_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> ($stable(ref_ratio) && $stable(fb_b) && $stable(fb_a) && $stable(func_bits) && !cnt_rst));

  a_r9_bad_ref_held: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word_code == CODE_REF && bad_word) |=> ($stable(ref_ratio) && cfg_err));

  a_r10_bad_fb_held: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word_code == CODE_FB && bad_word) |=> ($stable(fb_b) && $stable(fb_a) && !cnt_rst && cfg_err));

  a_r6_init_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word_code == CODE_INIT) |=> (cnt_rst && rst_armed));

  a_r5_func_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word_code == CODE_FUNC) |=> !cnt_rst);

  a_r7_armed_fb_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word_code == CODE_FB && !bad_word && rst_armed) |=> (cnt_rst && !rst_armed));
endmodule

bind synth_serial_port sp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .word_code(word_code),
  .bad_word(bad_word), .rst_armed(rst_armed), .ref_ratio(ref_ratio),
  .fb_b(fb_b), .fb_a(fb_a), .func_bits(func_bits), .cnt_rst(cnt_rst),
  .cfg_err(cfg_err)
);

// File: tb/synth_serial_port_bench.sv
`timescale 1ns/1ps
module synth_serial_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [13:0] ref_ratio;
  logic        ref_prec, fb_go, cnt_rst, cfg_err;
  logic [12:0] fb_b;
  logic [4:0]  fb_a;
  logic [17:0] func_bits;

  always #2.5 clk = ~clk;

  synth_serial_port u_synth_serial_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .ref_ratio(ref_ratio), .ref_prec(ref_prec), .fb_go(fb_go), .fb_b(fb_b),
    .fb_a(fb_a), .func_bits(func_bits), .cnt_rst(cnt_rst), .cfg_err(cfg_err)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [13:0] m_ratio; logic m_prec, m_go, m_err, m_armed;
  logic [12:0] m_b; logic [4:0] m_a; logic [17:0] m_fn;
  int exp_pulses;

  // strobe monitor
  int pcnt = 0, run = 0, maxrun = 0;
  always @(negedge clk) begin
    if (cnt_rst) begin pcnt++; run++; if (run > maxrun) maxrun = run; end
    else run = 0;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ratio = 0; m_prec = 0; m_go = 0; m_err = 0; m_armed = 0;
    m_b = 0; m_a = 0; m_fn = 0;
  endtask

  function automatic bit ratio_ok_b(input logic [13:0] r); return r > 14'd2; endfunction
  function automatic bit fb_ok_b(input logic [12:0] b, input logic [4:0] a);
    return (b > 13'd2) && !({8'd0, a} > b);
  endfunction

  task automatic model_apply(input logic [20:0] w);
    exp_pulses = 0;
    case (w[1:0])
      2'b00: if (ratio_ok_b(w[15:2])) begin m_ratio = w[15:2]; m_prec = w[20]; end
             else m_err = 1;
      2'b10: if (fb_ok_b(w[19:7], w[6:2])) begin
               m_go = w[20]; m_b = w[19:7]; m_a = w[6:2];
               if (m_armed) begin exp_pulses = 1; m_armed = 0; end
             end else m_err = 1;
      2'b01: m_fn = w[19:2];
      default: begin m_fn = w[19:2]; exp_pulses = 1; m_armed = 1; end
    endcase
  endtask

  task automatic clk_bit(input logic b);
    ser_dat = b; repeat (3) @(posedge clk);
    ser_clk = 1; repeat (3) @(posedge clk);
    ser_clk = 0; repeat (3) @(posedge clk);
  endtask

  task automatic check_all(input string tag);
    #1;
    chk({tag, " ref_ratio"}, ref_ratio, m_ratio);
    chk({tag, " ref_prec"}, ref_prec, m_prec);
    chk({tag, " fb_go"}, fb_go, m_go);
    chk({tag, " fb_b"}, fb_b, m_b);
    chk({tag, " fb_a"}, fb_a, m_a);
    chk({tag, " func_bits"}, func_bits, m_fn);
    chk({tag, " cfg_err"}, cfg_err, m_err);
  endtask

  // sends n bits of s, MSB first, then pulses load-enable
  task automatic send(input logic [31:0] s, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) clk_bit(s[i]);
    model_apply(s[20:0]);
    pcnt = 0; maxrun = 0;
    ser_le = 1; repeat (3) @(posedge clk);
    ser_le = 0; repeat (8) @(posedge clk);
    check_all(tag);
    chk({tag, " R7 strobe count"}, pcnt, exp_pulses);
    chk("R8 strobe width", (maxrun > 1), 0);
  endtask

  function automatic logic [20:0] w_ref(input logic p, input logic [13:0] r);
    return {p, 4'b0, r, 2'b00};
  endfunction
  function automatic logic [20:0] w_fb(input logic g, input logic [12:0] b, input logic [4:0] a);
    return {g, b, a, 2'b10};
  endfunction
  function automatic logic [20:0] w_fn(input logic [17:0] f, input logic init);
    return {1'b0, f, init, 1'b1};
  endfunction

  task automatic do_reset();
    rst_n = 0; repeat (4) @(posedge clk); rst_n = 1; repeat (2) @(posedge clk);
    model_reset();
  endtask

  initial begin
    void'($urandom(32'h5eed));
    model_reset();
    do_reset();
    check_all("R1 reset");
    chk("R1 strobe", cnt_rst, 0);

    send(w_ref(1'b1, 14'd50), 21, "R3 ref load");
    send(w_ref(1'b0, 14'd3), 21, "R3 ref min");
    send(w_fb(1'b1, 13'd148, 5'd14), 21, "R4 fb load");
    send(w_fn(18'h2A5C3, 1'b0), 21, "R5 func load");
    // extra leading bits must drop out
    send({11'h7FF, w_ref(1'b1, 14'd16383)}, 32, "R2 leading bits");
    // initialization then armed feedback load in same cycle as latch update
    send(w_fn(18'h15A3C, 1'b1), 21, "R6 init");
    send(w_fb(1'b0, 13'd2, 5'd0), 21, "R10 small B");
    send(w_fb(1'b0, 13'd5, 5'd9), 21, "R10 B below A");
    send(w_fb(1'b0, 13'd9, 5'd9), 21, "R7 armed fb");
    send(w_fb(1'b1, 13'd10, 5'd1), 21, "R7 second fb");
    send(w_ref(1'b0, 14'd2), 21, "R9 small ratio");
    send(w_fn(18'h00001, 1'b0), 21, "R11 err kept");

    // serial activity with load-enable low
    for (int i = 0; i < 21; i++) clk_bit(1'($urandom));
    repeat (6) @(posedge clk);
    check_all("R12 no load");

    do_reset();
    check_all("R11 cleared by reset");

    for (int k = 0; k < 200; k++) begin
      logic [20:0] w;
      w = 21'($urandom);
      if (w[1:0] == 2'b00 && ($urandom % 8) == 0) w[15:2] = 14'($urandom % 3);
      if (w[1:0] == 2'b10 && ($urandom % 2) == 0) w[19:7] = 13'($urandom % 40);
      send({11'd0, w}, 21, "R3 R4 R5 R6 R7 R9 R10 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule